// File: doc/BRIEF.md
# Charge-Path Protection Sequencer

This block is the digital core that decides whether the charge switch of a single-cell battery pack may stay on. It receives comparator outputs that are already logic levels: the cell is above the overvoltage limit, pack-negative is below the excess-charge-current limit, pack-negative is above the load-detect limit, and a charger is present. It turns these into two latched fault states and one charge-enable output.

Every fault entry and every fault exit is deglitched by its own step count. Steps normally come from an external 100 µs tick, so 1.2 ms and 250 ms are both exact counts. A two-bit delay-mode input selects one of three options. The first is normal tick counting. The second is a bypass in which each change takes effect at the next clock edge. The third is an accelerated mode in which every clock counts as a step.

An overvoltage fault is never cleared by a charger. It clears only when a load is seen, the cell is back below the limit, and no charger is present. The parameter FAST_VARIANT selects the short-delay defaults: 1 ms for overvoltage entry and 8 ms for excess charge current entry.

Top module: `chg_prot_seq`

## Requirements
- R1: After reset, chg_en_o is 1, ov_fault_o is 0 and ecc_fault_o is 0.
- R2: In normal mode (dly_mode_i = 2'b00 or 2'b11), ov_fault_o sets once ov_flag_i has been high on OV_DET_STEPS consecutive tick steps (default 2500 ticks, 250 ms).
- R3: A fault or release condition that drops before its step count is reached leaves the fault state unchanged and restarts its count.
- R4: ov_fault_o clears after OV_REL_STEPS steps (default 160, 16 ms) during which ov_flag_i is 0, load_flag_i is 1 and chg_present_i is 0.
- R5: While chg_present_i is 1, ov_fault_o never clears, even with a load present and the cell below the limit.
- R6: ecc_fault_o sets once ecc_flag_i has been high for ECC_DET_STEPS steps (default 160, 16 ms).
- R7: ecc_fault_o clears only after chg_present_i is 0 and load_flag_i is 1 for ECC_REL_STEPS steps (default 12, 1.2 ms).
- R8: When dly_mode_i = 2'b01 (bypass), a fault sets or clears at the first clock edge at which its condition is true.
- R9: When dly_mode_i = 2'b10 (accelerated), every clock cycle counts as one step, independent of tick_i.
- R10: chg_en_o is 0 whenever either fault is set, and it returns to 1 only after both faults have cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | One-cycle 100 µs timebase pulse |
| dly_mode_i | input | 2 | Delay mode: 00 normal, 01 bypass, 10 accelerated, 11 normal |
| ov_flag_i | input | 1 | Cell above the overvoltage limit |
| ecc_flag_i | input | 1 | Pack-negative below the excess-charge-current limit |
| load_flag_i | input | 1 | Pack-negative above the load-detect limit |
| chg_present_i | input | 1 | Charger connected |
| chg_en_o | output | 1 | Charge switch enable |
| ov_fault_o | output | 1 | Overvoltage fault latched |
| ecc_fault_o | output | 1 | Excess charge current fault latched |

## Verification
Directed sequences drive each flag for one step count short of its limit and then well past it, which separates correct deglitching from an off-by-one error or from no filtering at all. Release attempts are made both with the charger connected and with it disconnected, which shows whether the charger gating is present for each fault. A phase with overlapping faults that have different release times shows whether the enable waits for every fault. Random segments in accelerated and normal modes are then compared cycle by cycle against a bench model of the requirements. Bypass and accelerated runs confirm the one-edge response and the per-clock stepping.

// File: rtl/chg_prot_pkg.sv
package chg_prot_pkg;
  typedef enum logic [1:0] {
    DLY_NORMAL = 2'b00,
    DLY_BYPASS = 2'b01,
    DLY_ACCEL  = 2'b10,
    DLY_RSVD   = 2'b11
  } dly_mode_e;

  function automatic int unsigned max2(int unsigned a, int unsigned b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/prot_step_gen.sv
module prot_step_gen
  import chg_prot_pkg::*;
(
  input  logic       tick_i,
  input  logic [1:0] dly_mode_i,
  output logic       step_o,
  output logic       bypass_o
);
  dly_mode_e mode;

  always_comb begin
    mode     = dly_mode_e'(dly_mode_i);
    bypass_o = (mode == DLY_BYPASS);
    unique case (mode)
      DLY_BYPASS, DLY_ACCEL: step_o = 1'b1;
      default:               step_o = tick_i;
    endcase
  end
endmodule

// File: rtl/prot_fault_latch.sv
module prot_fault_latch
  import chg_prot_pkg::*;
#(
  parameter int unsigned DET_STEPS = 160,
  parameter int unsigned REL_STEPS = 12
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic step_i,
  input  logic bypass_i,
  input  logic set_i,
  input  logic clr_i,
  output logic fault_o
);
  localparam int unsigned MaxSteps = max2(DET_STEPS, REL_STEPS);
  localparam int unsigned CntW     = $clog2(MaxSteps + 1);

  logic            fault_q;
  logic [CntW-1:0] cnt_q;
  logic [CntW-1:0] lim;
  logic            cond;
  logic            done;

  // one counter serves entry and exit; the state picks the condition and limit
  always_comb begin
    cond = fault_q ? clr_i : set_i;
    lim  = fault_q ? CntW'(REL_STEPS) : CntW'(DET_STEPS);
    done = bypass_i || (cnt_q == lim - CntW'(1));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fault_q <= 1'b0;
      cnt_q   <= '0;
    end else if (!cond) begin
      cnt_q   <= '0;
    end else if (step_i) begin
      if (done) begin
        fault_q <= ~fault_q;
        cnt_q   <= '0;
      end else begin
        cnt_q   <= cnt_q + CntW'(1);
      end
    end
  end

  assign fault_o = fault_q;

  p_cnt_bound_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q < CntW'(MaxSteps));
  p_rise_cause_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(fault_q) |-> $past(set_i));
  p_fall_cause_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(fault_q) |-> $past(clr_i));
  p_bypass_set_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(bypass_i) && $past(set_i) && !$past(fault_q)) |-> fault_q);
endmodule

// File: rtl/chg_prot_seq.sv
module chg_prot_seq
  import chg_prot_pkg::*;
#(
  parameter bit          FAST_VARIANT  = 1'b0,
  parameter int unsigned OV_DET_STEPS  = FAST_VARIANT ? 10 : 2500,
  parameter int unsigned OV_REL_STEPS  = 160,
  parameter int unsigned ECC_DET_STEPS = FAST_VARIANT ? 80 : 160,
  parameter int unsigned ECC_REL_STEPS = 12
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic [1:0] dly_mode_i,
  input  logic       ov_flag_i,
  input  logic       ecc_flag_i,
  input  logic       load_flag_i,
  input  logic       chg_present_i,
  output logic       chg_en_o,
  output logic       ov_fault_o,
  output logic       ecc_fault_o
);
  logic step, bypass;
  logic ov_clr, ecc_clr;

  prot_step_gen u_step (
    .tick_i     (tick_i),
    .dly_mode_i (dly_mode_i),
    .step_o     (step),
    .bypass_o   (bypass)
  );

  // overvoltage exit needs a load with no charger attached
  assign ov_clr  = !ov_flag_i && load_flag_i && !chg_present_i;
  assign ecc_clr = load_flag_i && !chg_present_i;

  prot_fault_latch #(.DET_STEPS(OV_DET_STEPS), .REL_STEPS(OV_REL_STEPS)) u_ov (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .step_i   (step),
    .bypass_i (bypass),
    .set_i    (ov_flag_i),
    .clr_i    (ov_clr),
    .fault_o  (ov_fault_o)
  );

  prot_fault_latch #(.DET_STEPS(ECC_DET_STEPS), .REL_STEPS(ECC_REL_STEPS)) u_ecc (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .step_i   (step),
    .bypass_i (bypass),
    .set_i    (ecc_flag_i),
    .clr_i    (ecc_clr),
    .fault_o  (ecc_fault_o)
  );

  assign chg_en_o = !(ov_fault_o || ecc_fault_o);

  p_chg_blocks_ov_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ov_fault_o) |-> !$past(chg_present_i));
  p_ecc_rel_gate_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ecc_fault_o) |-> ($past(load_flag_i) && !$past(chg_present_i)));
endmodule

// File: tb/tb_chg_prot_seq.sv
`timescale 1ns/1ps
module tb_chg_prot_seq;
  localparam int OV_DET  = 2500;
  localparam int OV_REL  = 160;
  localparam int ECC_DET = 160;
  localparam int ECC_REL = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0;
  logic [1:0] mode = 2'b00;
  logic ov = 1'b0, ecc = 1'b0, load = 1'b0, chg = 1'b0;
  logic chg_en, ov_f, ecc_f;
  int   errs = 0, checks = 0;
  int   tdiv = 0;
  bit   done = 1'b0;

  always #2 clk = ~clk;

  chg_prot_seq dut (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .dly_mode_i(mode),
    .ov_flag_i(ov), .ecc_flag_i(ecc), .load_flag_i(load), .chg_present_i(chg),
    .chg_en_o(chg_en), .ov_fault_o(ov_f), .ecc_fault_o(ecc_f)
  );

  always @(negedge clk) begin
    tick <= (tdiv % 4) == 3;
    tdiv <= tdiv + 1;
  end

  // requirement model: a condition held for N consecutive steps flips the state
  logic m_ov = 1'b0, m_ecc = 1'b0;
  int   c_ov = 0, c_ecc = 0;
  function automatic bit m_step(logic [1:0] md, logic tk);
    return (md == 2'b01) || (md == 2'b10) || tk;
  endfunction
  function automatic int lim_of(logic [1:0] md, int n);
    return (md == 2'b01) ? 1 : n;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ov <= 1'b0; m_ecc <= 1'b0; c_ov <= 0; c_ecc <= 0;
    end else begin
      if (!(m_ov ? (!ov && load && !chg) : ov)) c_ov <= 0;
      else if (m_step(mode, tick)) begin
        if (c_ov + 1 >= lim_of(mode, m_ov ? OV_REL : OV_DET)) begin
          m_ov <= ~m_ov; c_ov <= 0;
        end else c_ov <= c_ov + 1;
      end
      if (!(m_ecc ? (load && !chg) : ecc)) c_ecc <= 0;
      else if (m_step(mode, tick)) begin
        if (c_ecc + 1 >= lim_of(mode, m_ecc ? ECC_REL : ECC_DET)) begin
          m_ecc <= ~m_ecc; c_ecc <= 0;
        end else c_ecc <= c_ecc + 1;
      end
    end
  end

  task automatic chk(string req, string what, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s %s: actual=%0b expected=%0b", req, what, act, exp);
    end
  endtask

  task automatic chk_model(string req);
    chk(req, "ov_fault", ov_f, m_ov);
    chk(req, "ecc_fault", ecc_f, m_ecc);
    chk(req, "chg_en", chg_en, !(m_ov || m_ecc));
  endtask

  task automatic cyc(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  endtask

  initial begin
    #(190000 * 4);
    if (!done) begin
      errs++; checks++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    void'($urandom(32'd1234));
    cyc(3);
    // R1 reset state
    chk("R1", "chg_en", chg_en, 1'b1);
    chk("R1", "ov_fault", ov_f, 1'b0);
    chk("R1", "ecc_fault", ecc_f, 1'b0);
    rst_n = 1'b1;
    cyc(2);
    chk("R1", "chg_en after release", chg_en, 1'b1);

    // R3 short overvoltage excursion ignored
    ov = 1'b1; cyc((OV_DET - 10) * 4);
    ov = 1'b0; cyc(8);
    chk("R3", "ov short pulse", ov_f, 1'b0);
    chk_model("R3");

    // R2 sustained overvoltage
    ov = 1'b1; cyc((OV_DET + 10) * 4);
    chk("R2", "ov set", ov_f, 1'b1);
    chk("R10", "chg_en low on ov", chg_en, 1'b0);
    chk_model("R2");

    // R5 charger blocks release
    ov = 1'b0; load = 1'b1; chg = 1'b1; cyc((OV_REL * 3) * 4);
    chk("R5", "ov held with charger", ov_f, 1'b1);

    // R3 release shorter than its delay ignored
    chg = 1'b0; cyc((OV_REL - 10) * 4);
    chg = 1'b1; cyc(8);
    chk("R3", "ov short release", ov_f, 1'b1);

    // R4 release with load and no charger
    chg = 1'b0; cyc((OV_REL + 10) * 4);
    chk("R4", "ov cleared", ov_f, 1'b0);
    chk("R4", "chg_en back", chg_en, 1'b1);
    chk_model("R4");

    // R6 excess charge current
    load = 1'b0; chg = 1'b1;
    ecc = 1'b1; cyc((ECC_DET - 20) * 4);
    ecc = 1'b0; cyc(8);
    chk("R3", "ecc short pulse", ecc_f, 1'b0);
    ecc = 1'b1; cyc((ECC_DET + 10) * 4);
    chk("R6", "ecc set", ecc_f, 1'b1);
    chk("R10", "chg_en low on ecc", chg_en, 1'b0);
    ecc = 1'b0; load = 1'b1; cyc(60 * 4);
    chk("R7", "ecc held with charger", ecc_f, 1'b1);
    chg = 1'b0; cyc((ECC_REL + 4) * 4);
    chk("R7", "ecc cleared", ecc_f, 1'b0);
    chk_model("R7");

    // R10 both faults, different release times
    load = 1'b0; chg = 1'b1; ov = 1'b1; ecc = 1'b1;
    cyc((OV_DET + 10) * 4);
    chk("R10", "both set ov", ov_f, 1'b1);
    chk("R10", "both set ecc", ecc_f, 1'b1);
    ov = 1'b0; ecc = 1'b0; chg = 1'b0; load = 1'b1;
    cyc(50 * 4);
    chk("R10", "ecc released first", ecc_f, 1'b0);
    chk("R10", "chg_en waits for ov", chg_en, 1'b0);
    cyc((OV_REL + 10) * 4);
    chk("R10", "chg_en after all clear", chg_en, 1'b1);
    chk_model("R10");

    // R8 bypass mode
    load = 1'b0; mode = 2'b01; ov = 1'b1;
    cyc(1);
    chk("R8", "ov set next edge", ov_f, 1'b1);
    ov = 1'b0; load = 1'b1;
    cyc(1);
    chk("R8", "ov clear next edge", ov_f, 1'b0);
    load = 1'b0; ecc = 1'b1;
    cyc(1);
    chk("R8", "ecc set next edge", ecc_f, 1'b1);
    ecc = 1'b0; load = 1'b1;
    cyc(1);
    chk("R8", "ecc clear next edge", ecc_f, 1'b0);

    // R9 accelerated mode: one step per clock
    load = 1'b0; mode = 2'b10; cyc(2);
    ov = 1'b1; cyc(OV_DET - 1);
    chk("R9", "ov one cycle early", ov_f, 1'b0);
    cyc(1);
    chk("R9", "ov at exact count", ov_f, 1'b1);
    ov = 1'b0; load = 1'b1; cyc(OV_REL);
    chk("R9", "ov release at count", ov_f, 1'b0);

    // random segments against the model
    for (int s = 0; s < 40; s++) begin
      int len;
      mode = ($urandom % 4 == 0) ? 2'b00 : (($urandom % 2) ? 2'b10 : 2'b11);
      ov   = ($urandom % 3) == 0;
      ecc  = ($urandom % 3) == 0;
      load = ($urandom % 2) == 1;
      chg  = ($urandom % 2) == 1;
      len  = ($urandom % 5 == 0) ? 2600 + ($urandom % 200) : 1 + ($urandom % 400);
      for (int k = 0; k < len; k++) begin
        @(negedge clk);
        if (k % 16 == 0) chk_model("R3");
      end
    end

    done = 1'b1;
    finish_run();
  end
endmodule